// File: doc/BRIEF.md
# Dual-Input Capture Timer for Pulse-Width Measurement

This block is a 16-bit up-counter with two capture registers. Each capture register is loaded from the counter when a chosen edge arrives on an external input. The routing is crossed. An edge on input A loads capture register 1, and an edge on input B loads capture register 0. Each input can be set to detect rising edges, falling edges, both, or none. With both-edge detection, the high phase and the low phase of a signal can each be timed from two successive captures.

A small helper path sits behind each capture register. It keeps the previous captured value and emits a valid-strobed width, which is the new capture minus the previous one, taken modulo 2^16. A counter wrap between the two captures is therefore absorbed, because the borrow is simply dropped.

A sticky overflow flag records every wrap from FFFFh to 0000h. In restart mode, each A edge also clears the counter, so a single capture gives the elapsed time directly.

The counter is driven by a small state machine. Its state register also holds the operating mode, and it is written through the configuration strobe:
- ST_STOP: the counter holds. It is entered after reset, and on a write of mode 00 or 11.
- ST_FREE: the counter increments every cycle and wraps. It is entered on a write of mode 01.
- ST_CLRA: the counter increments, and each A edge restarts it from 0000h. It is entered on a write of mode 10.

Any state can move to any other state on a configuration write (transitions STOP→FREE, STOP→CLRA, FREE→CLRA, CLRA→FREE, and any state →STOP). Without a write, the state stays where it is.

Top module: `capture_timer`

## Requirements
- R1: A synchronous active-low reset clears the following to zero: the counter, both capture registers, both previous-capture registers, both width outputs, both interrupt pulses and the overflow flag. Reset also sets the mode to stopped and both edge selections to none.
- R2: In mode 01, the counter increases by one every clock cycle and wraps from FFFFh to 0000h.
- R3: In modes 00 and 11, the counter holds its value.
- R4: The overflow flag is set on a wrap and stays set until a write with `ovf_wdata` = 0 clears it. A write with `ovf_wdata` = 1 has no effect on the flag.
- R5: If a wrap and a clearing write of the overflow flag happen in the same cycle, the flag ends up set.
- R6: A selected edge on `in_a` loads `cap1_o`, and a selected edge on `in_b` loads `cap0_o`. An input level change present at clock edge k produces the capture at edge k+2. The value loaded is the count held just before edge k+2. A capture register that sees no selected edge on its input keeps its value.
- R7: Each input has its own 2-bit edge selection:
  - 00 detects no edges;
  - 01 detects rising edges only;
  - 10 detects falling edges only;
  - 11 detects both edges.
- R8: Each capture raises its own interrupt output for exactly one cycle, in the same cycle that the new capture value appears.
- R9: One cycle after each capture, the matching width output presents (new capture − previous capture) mod 2^16 with its valid strobe. The previous value starts at 0 after reset.
- R10: In mode 10, a selected A edge loads 0000h into the counter at the capture edge, and the counter then counts up again. A capture taken N cycles after the previous A capture therefore reads N−1. In this mode the counter does not wrap or set the overflow flag on a restart cycle.
- R11: A capture and a clearing write of the overflow flag in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Strobe that writes the mode and both edge selections |
| cfg_mode | input | 2 | Mode: 00 stop, 01 free-run, 10 restart on A, 11 stop |
| cfg_edge_a | input | 2 | Edge selection for `in_a` |
| cfg_edge_b | input | 2 | Edge selection for `in_b` |
| ovf_we | input | 1 | Write strobe for the overflow flag |
| ovf_wdata | input | 1 | Written value; 0 clears the flag, 1 does nothing |
| in_a | input | 1 | Asynchronous capture input A |
| in_b | input | 1 | Asynchronous capture input B |
| cnt_o | output | 16 | Current counter value |
| cap0_o | output | 16 | Capture register 0 (loaded by B) |
| cap1_o | output | 16 | Capture register 1 (loaded by A) |
| irq_cap0_o | output | 1 | One-cycle pulse on each load of capture register 0 |
| irq_cap1_o | output | 1 | One-cycle pulse on each load of capture register 1 |
| ovf_o | output | 1 | Sticky overflow flag |
| wid0_valid_o | output | 1 | Width 0 valid strobe |
| wid0_o | output | 16 | Width between successive loads of capture register 0 |
| wid1_valid_o | output | 1 | Width 1 valid strobe |
| wid1_o | output | 16 | Width between successive loads of capture register 1 |

## Verification
The results fall due at different edges:
- Counter steps, overflow changes and mode changes appear one edge after their cause.
- A capture and its interrupt appear at the third rising edge after the input changes: two synchronizer edges, then the capture edge.
- The width strobe follows one edge after that.

The bench drives inputs just after a falling edge and samples every output at the next falling edge. It also keeps a behavioural model that advances once per rising edge, so each comparison lands exactly where the result is due. The directed checks count the same number of edges from the stimulus: three ticks for a capture, four for a width, and one for a flag write.

// File: rtl/capt_pkg.sv
package capt_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        MODE_STOP = 2'b00,
        MODE_FREE = 2'b01,
        MODE_CLRA = 2'b10,
        MODE_HALT = 2'b11
    } mode_e;

    typedef enum logic [1:0] {
        EDGE_NONE = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_e;

    typedef enum logic [1:0] {
        ST_STOP = 2'b00,
        ST_FREE = 2'b01,
        ST_CLRA = 2'b10
    } cnt_state_e;

endpackage

// File: rtl/capt_edge.sv
module capt_edge
    import capt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  pin,
    input  edge_e sel,
    output logic  evt_o
);

    logic [STAGES-1:0] sync_q;
    logic              hist_q;
    logic              lvl;
    logic              rise;
    logic              fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], pin};
            hist_q <= sync_q[STAGES-1];
        end
    end

    always_comb begin
        lvl  = sync_q[STAGES-1];
        rise = lvl & ~hist_q;
        fall = ~lvl & hist_q;
        unique case (sel)
            EDGE_NONE: evt_o = 1'b0;
            EDGE_RISE: evt_o = rise;
            EDGE_FALL: evt_o = fall;
            EDGE_BOTH: evt_o = rise | fall;
            default:   evt_o = 1'b0;
        endcase
    end

    AST_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_NONE) |-> !evt_o); // R7

endmodule

// File: rtl/capt_counter.sv
module capt_counter
    import capt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  mode_e            cfg_mode,
    input  logic             restart_i,
    input  logic             ovf_we,
    input  logic             ovf_wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    cnt_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             ovf_q, ovf_d;
    logic             wrap;

    // next-state: the state register doubles as the mode register
    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            unique case (cfg_mode)
                MODE_FREE: st_d = ST_FREE;
                MODE_CLRA: st_d = ST_CLRA;
                default:   st_d = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_STOP;
        else        st_q <= st_d;
    end

    // per-state outputs
    always_comb begin
        cnt_d = cnt_q;
        wrap  = 1'b0;
        unique case (st_q)
            ST_STOP: cnt_d = cnt_q;
            ST_FREE: begin
                cnt_d = cnt_q + CNT_ONE;
                wrap  = (cnt_q == CNT_MAX);
            end
            ST_CLRA: begin
                if (restart_i) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_ONE;
                    wrap  = (cnt_q == CNT_MAX);
                end
            end
            default: cnt_d = cnt_q;
        endcase
        if (wrap)                       ovf_d = 1'b1;
        else if (ovf_we && !ovf_wdata)  ovf_d = 1'b0;
        else                            ovf_d = ovf_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            ovf_q <= ovf_d;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = ovf_q;

    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_FREE) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R2
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STOP) |=> $stable(cnt_q)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !(ovf_we && !ovf_wdata)) |=> ovf_q); // R4
    AST_WRAP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_STOP) && (cnt_q == CNT_MAX) && !((st_q == ST_CLRA) && restart_i)) |=> ovf_q); // R5
    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_CLRA) && restart_i) |=> (cnt_q == '0)); // R10

endmodule

// File: rtl/capt_channel.sv
module capt_channel #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [CNT_W-1:0] cap_o,
    output logic             irq_o,
    output logic [CNT_W-1:0] wid_o,
    output logic             wid_vld_o
);

    logic [CNT_W-1:0] cap_q;
    logic [CNT_W-1:0] prev_q;
    logic [CNT_W-1:0] wid_q;
    logic             irq_q;
    logic             vld_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q  <= '0;
            prev_q <= '0;
            wid_q  <= '0;
            irq_q  <= 1'b0;
            vld_q  <= 1'b0;
        end else begin
            irq_q <= trig_i;
            if (trig_i) cap_q <= cnt_i;
            vld_q <= irq_q;
            if (irq_q) begin
                wid_q  <= cap_q - prev_q;
                prev_q <= cap_q;
            end
        end
    end

    assign cap_o     = cap_q;
    assign irq_o     = irq_q;
    assign wid_o     = wid_q;
    assign wid_vld_o = vld_q;

    AST_CAP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (cap_q == $past(cnt_i))); // R6
    AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> $stable(cap_q)); // R6
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> irq_q); // R8
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_i |=> !irq_q); // R8
    AST_WID_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |=> vld_q); // R9

endmodule

// File: rtl/capture_timer.sv
module capture_timer
    import capt_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic [1:0]       cfg_edge_a,
    input  logic [1:0]       cfg_edge_b,
    input  logic             ovf_we,
    input  logic             ovf_wdata,
    input  logic             in_a,
    input  logic             in_b,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cap0_o,
    output logic [CNT_W-1:0] cap1_o,
    output logic             irq_cap0_o,
    output logic             irq_cap1_o,
    output logic             ovf_o,
    output logic             wid0_valid_o,
    output logic [CNT_W-1:0] wid0_o,
    output logic             wid1_valid_o,
    output logic [CNT_W-1:0] wid1_o
);

    // index 0 is input A, index 1 is input B
    logic [NUM_CH-1:0] pin_w;
    logic [NUM_CH-1:0] evt_w;
    edge_e             sel_q [NUM_CH];
    edge_e             sel_in [NUM_CH];
    logic [CNT_W-1:0]  cnt_w;
    logic [CNT_W-1:0]  cap_w  [NUM_CH];
    logic [CNT_W-1:0]  wid_w  [NUM_CH];
    logic [NUM_CH-1:0] irq_w;
    logic [NUM_CH-1:0] vld_w;

    assign pin_w     = {in_b, in_a};
    assign sel_in[0] = edge_e'(cfg_edge_a);
    assign sel_in[1] = edge_e'(cfg_edge_b);

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_CH; i++) begin
            if (!rst_n)      sel_q[i] <= EDGE_NONE;
            else if (cfg_we) sel_q[i] <= sel_in[i];
        end
    end

    generate
        for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_in
            capt_edge #(.STAGES(SYNC_STAGES)) u_edge (
                .clk   (clk),
                .rst_n (rst_n),
                .pin   (pin_w[gi]),
                .sel   (sel_q[gi]),
                .evt_o (evt_w[gi])
            );
        end
        // crossed routing: channel i is loaded by the other input
        for (genvar gc = 0; gc < NUM_CH; gc++) begin : g_ch
            capt_channel #(.CNT_W(CNT_W)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .trig_i    (evt_w[NUM_CH-1-gc]),
                .cnt_i     (cnt_w),
                .cap_o     (cap_w[gc]),
                .irq_o     (irq_w[gc]),
                .wid_o     (wid_w[gc]),
                .wid_vld_o (vld_w[gc])
            );
        end
    endgenerate

    capt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_mode  (mode_e'(cfg_mode)),
        .restart_i (evt_w[0]),
        .ovf_we    (ovf_we),
        .ovf_wdata (ovf_wdata),
        .cnt_o     (cnt_w),
        .ovf_o     (ovf_o)
    );

    assign cnt_o        = cnt_w;
    assign cap0_o       = cap_w[0];
    assign cap1_o       = cap_w[1];
    assign irq_cap0_o   = irq_w[0];
    assign irq_cap1_o   = irq_w[1];
    assign wid0_o       = wid_w[0];
    assign wid1_o       = wid_w[1];
    assign wid0_valid_o = vld_w[0];
    assign wid1_valid_o = vld_w[1];

    AST_CROSS_A: assert property (@(posedge clk) disable iff (!rst_n)
        evt_w[0] |=> irq_cap1_o); // R6
    AST_CROSS_B: assert property (@(posedge clk) disable iff (!rst_n)
        evt_w[1] |=> irq_cap0_o); // R6

endmodule

// File: tb/tb_capture_timer.sv
module tb_capture_timer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we, ovf_we, ovf_wdata, in_a, in_b;
    logic [1:0]  cfg_mode, cfg_edge_a, cfg_edge_b;
    logic [15:0] cnt_o, cap0_o, cap1_o, wid0_o, wid1_o;
    logic        irq_cap0_o, irq_cap1_o, ovf_o, wid0_valid_o, wid1_valid_o;

    int total = 0;
    int fails = 0;
    int cyc   = 0;
    bit done  = 0;

    always #2 clk = ~clk;   // 250 MHz

    capture_timer dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_edge_a(cfg_edge_a), .cfg_edge_b(cfg_edge_b), .ovf_we(ovf_we),
        .ovf_wdata(ovf_wdata), .in_a(in_a), .in_b(in_b), .cnt_o(cnt_o),
        .cap0_o(cap0_o), .cap1_o(cap1_o), .irq_cap0_o(irq_cap0_o),
        .irq_cap1_o(irq_cap1_o), .ovf_o(ovf_o), .wid0_valid_o(wid0_valid_o),
        .wid0_o(wid0_o), .wid1_valid_o(wid1_valid_o), .wid1_o(wid1_o)
    );

    // behavioural reference model, one step per rising edge
    int m_cnt, m_ovf, m_mode, m_ea, m_eb;
    int m_cap0, m_cap1, m_irq0, m_irq1, m_p0, m_p1, m_w0, m_w1, m_wv0, m_wv1;
    int a1, a2, a3, b1, b2, b3;
    int ea, eb, wrap, n_cnt;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ovf = 0; m_mode = 0; m_ea = 0; m_eb = 0;
            m_cap0 = 0; m_cap1 = 0; m_irq0 = 0; m_irq1 = 0; m_p0 = 0; m_p1 = 0;
            m_w0 = 0; m_w1 = 0; m_wv0 = 0; m_wv1 = 0;
            a1 = 0; a2 = 0; a3 = 0; b1 = 0; b2 = 0; b3 = 0;
        end else begin
            ea = (a2 != a3) && ((a2 == 1 && (m_ea % 2) == 1) || (a2 == 0 && m_ea >= 2));
            eb = (b2 != b3) && ((b2 == 1 && (m_eb % 2) == 1) || (b2 == 0 && m_eb >= 2));
            wrap = 0;
            if (m_mode == 1 || (m_mode == 2 && !ea)) begin
                wrap  = (m_cnt == 65535);
                n_cnt = (m_cnt + 1) % 65536;
            end else if (m_mode == 2) n_cnt = 0;
            else n_cnt = m_cnt;
            m_wv0 = m_irq0; m_wv1 = m_irq1;
            if (m_irq0) begin m_w0 = (m_cap0 - m_p0 + 65536) % 65536; m_p0 = m_cap0; end
            if (m_irq1) begin m_w1 = (m_cap1 - m_p1 + 65536) % 65536; m_p1 = m_cap1; end
            m_irq1 = ea; if (ea) m_cap1 = m_cnt;
            m_irq0 = eb; if (eb) m_cap0 = m_cnt;
            m_cnt = n_cnt;
            if (wrap) m_ovf = 1;
            else if (ovf_we && !ovf_wdata) m_ovf = 0;
            if (cfg_we) begin
                m_mode = int'(cfg_mode); m_ea = int'(cfg_edge_a); m_eb = int'(cfg_edge_b);
            end
            a3 = a2; a2 = a1; a1 = int'(in_a);
            b3 = b2; b2 = b1; b1 = int'(in_b);
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cmp_all();
        chk("R2 count vs model", int'(cnt_o), m_cnt);
        chk("R4 overflow vs model", int'(ovf_o), m_ovf);
        chk("R6 cap0 vs model", int'(cap0_o), m_cap0);
        chk("R6 cap1 vs model", int'(cap1_o), m_cap1);
        chk("R8 irq0 vs model", int'(irq_cap0_o), m_irq0);
        chk("R8 irq1 vs model", int'(irq_cap1_o), m_irq1);
        chk("R9 wid0 valid vs model", int'(wid0_valid_o), m_wv0);
        chk("R9 wid1 valid vs model", int'(wid1_valid_o), m_wv1);
        chk("R9 wid0 vs model", int'(wid0_o), m_w0);
        chk("R9 wid1 vs model", int'(wid1_o), m_w1);
    endtask

    task automatic tick();
        @(negedge clk);
        cmp_all();
    endtask

    task automatic cfg(input int mode, input int sa, input int sb);
        cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_edge_a = 2'(sa); cfg_edge_b = 2'(sb);
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic count_irq(input int n, inout int c1, inout int c0);
        for (int i = 0; i < n; i++) begin
            tick();
            c1 += int'(irq_cap1_o);
            c0 += int'(irq_cap0_o);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            total++; fails++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin : stim
        int c, n1, n0, lfsr;
        bit prev_clr;
        rst_n = 1'b0; cfg_we = 0; cfg_mode = 0; cfg_edge_a = 0; cfg_edge_b = 0;
        ovf_we = 0; ovf_wdata = 0; in_a = 0; in_b = 0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R1 reset count", int'(cnt_o), 0);
        chk("R1 reset cap0", int'(cap0_o), 0);
        chk("R1 reset cap1", int'(cap1_o), 0);
        chk("R1 reset overflow", int'(ovf_o), 0);
        chk("R1 reset irq", int'(irq_cap0_o | irq_cap1_o), 0);
        repeat (4) tick();
        chk("R3 stopped after reset", int'(cnt_o), 0);

        // free run, both edges
        cfg(1, 3, 3);
        tick();
        c = int'(cnt_o);
        in_b = 1;
        repeat (3) tick();
        chk("R6 B loads cap0 at k+2", int'(cap0_o), c + 2);
        chk("R8 irq0 raised", int'(irq_cap0_o), 1);
        chk("R6 A channel untouched", int'(irq_cap1_o), 0);
        tick();
        chk("R8 irq0 one cycle", int'(irq_cap0_o), 0);
        chk("R9 wid0 valid", int'(wid0_valid_o), 1);
        chk("R9 first width from zero", int'(wid0_o), c + 2);
        repeat (3) tick();
        in_b = 0;
        repeat (4) tick();
        chk("R9 high phase width", int'(wid0_o), 7);

        lfsr = 32'h1ACE;
        for (int i = 0; i < 300; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            if ((lfsr & 3) == 0) in_a = ~in_a;
            if ((lfsr & 12) == 4) in_b = ~in_b;
            tick();
        end
        in_a = 0; in_b = 0;
        repeat (6) tick();

        // edge selection
        cfg(1, 1, 0);
        n1 = 0; n0 = 0;
        in_a = 1; in_b = 1; count_irq(10, n1, n0);
        in_a = 0; in_b = 0; count_irq(10, n1, n0);
        chk("R7 rise only one capture", n1, 1);
        chk("R7 none on B no capture", n0, 0);
        cfg(1, 2, 0);
        n1 = 0; n0 = 0;
        in_a = 1; count_irq(10, n1, n0);
        in_a = 0; count_irq(10, n1, n0);
        chk("R7 fall only one capture", n1, 1);
        cfg(1, 0, 0);
        n1 = 0; n0 = 0;
        in_a = 1; count_irq(10, n1, n0);
        in_a = 0; count_irq(10, n1, n0);
        chk("R7 none on A no capture", n1, 0);

        // wrap with width spanning it
        cfg(1, 3, 3);
        while (cnt_o != 16'hFFE0) tick();
        in_a = 1;
        prev_clr = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (prev_clr) chk("R5 wrap beats clear", int'(ovf_o), 1);
            prev_clr = (cnt_o == 16'hFFFF);
            ovf_we = prev_clr; ovf_wdata = 0;
        end
        ovf_we = 0;
        in_a = 0;
        repeat (4) tick();
        chk("R9 width across wrap valid", int'(wid1_valid_o), 1);
        chk("R9 width across wrap", int'(wid1_o), 40);

        ovf_we = 1; ovf_wdata = 1;
        tick();
        ovf_we = 0;
        tick();
        chk("R4 write 1 keeps flag", int'(ovf_o), 1);

        in_b = 1;
        repeat (2) tick();
        ovf_we = 1; ovf_wdata = 0;
        tick();
        ovf_we = 0;
        chk("R11 capture with clear", int'(irq_cap0_o), 1);
        chk("R11 clear with capture", int'(ovf_o), 0);
        tick();
        chk("R4 flag stays clear", int'(ovf_o), 0);
        in_b = 0;
        repeat (6) tick();

        // restart on A
        cfg(2, 3, 3);
        for (int j = 0; j < 4; j++) begin
            in_a = ~in_a;
            repeat (30) tick();
        end
        chk("R10 restart capture", int'(cap1_o), 29);
        chk("R10 count since restart", int'(cnt_o), 27);

        cfg(3, 3, 3);
        c = int'(cnt_o);
        repeat (5) tick();
        chk("R3 mode 11 holds", int'(cnt_o), c);
        finish_run();
    end

endmodule